// File: doc/BRIEF.md
# Multi-Mode Transmit Line Encoder

This block turns a serial payload into a chip stream for a transmitter modulator. Two strobes set all timing. The bit strobe marks the start of each bit period. The chip strobe runs at twice that rate and marks both half-bit boundaries. The data source is asked for each new bit with a one-cycle request pulse. The encoder samples that bit at the next bit start and holds it for the whole period. Output transitions therefore follow only the strobes and never the timing of the input.

A three-bit mode selector picks one of six line codes:
- two Manchester polarities,
- Bi-Phase Mark,
- Bi-Phase Space,
- an internal nine-stage pseudo-random test pattern,
- a transparent bypass.

The selector is captured only while the encoder is disabled, so a running stream never changes code part-way through a bit. While disabled, the output rests low and no data is requested.

Top module: `txline_encoder`

## Requirements
- R1: The mode selector codes are 0 Manchester-A, 1 Manchester-B, 2 Bi-Phase Mark, 3 Bi-Phase Space, 4 pseudo-random pattern, and 5, 6, 7 transparent. The code is captured on every clock while `enc_en` is low.
- R2: `din` is sampled only at a bit start, which is a clock edge with `enc_en`, `bit_stb` and `chip_stb` all high. `chip_out` changes only on the clock after a `chip_stb`, or when the encoder is disabled. Within each bit, chip 0 is the first half and chip 1 is the second half.
- R3: In Manchester-A a 0 gives chips (0,1) and a 1 gives chips (1,0).
- R4: In Manchester-B a 0 gives chips (1,0) and a 1 gives chips (0,1).
- R5: In Bi-Phase Mark the level inverts at every bit start, and inverts again at mid-bit only for a 1.
- R6: In Bi-Phase Space the level inverts at every bit start, and inverts again at mid-bit only for a 0.
- R7: The Bi-Phase level is low while disabled, so the first chip after enabling is 1.
- R8: The pattern mode sends bits b[n] with b[0..8] = 1 and b[n] = b[n-9] xor b[n-5]. Each bit fills both of its chips. The sequence repeats every 511 bits, and the generator state is never all zeros.
- R9: The transparent codes put the sampled bit on both chips of its bit period.
- R10: `din_req` is a one-cycle pulse on the clock after each bit start in every mode except the pattern mode, where it stays low.
- R11: While `enc_en` is low, `chip_out` and `din_req` are 0 from the next clock on.
- R12: A change of `mode_sel` while enabled has no effect on the encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | Bit-period start strobe, coincident with a chip_stb |
| chip_stb | input | 1 | Half-bit strobe, twice the bit rate |
| enc_en | input | 1 | Encoder run enable |
| mode_sel | input | 3 | Line-code selector, captured while disabled |
| din | input | 1 | Serial payload bit |
| din_req | output | 1 | One-cycle request for the next payload bit |
| chip_out | output | 1 | Encoded chip stream |

## Verification
Some properties are checked by embedded assertions on every clock:
- the output changes only after a chip strobe,
- requests follow bit starts,
- the disabled state is quiet,
- the latched mode is frozen while running,
- Manchester always inverts at mid-bit and Bi-Phase always inverts at a bit start,
- the pattern register never reaches zero.

Other behaviour only the bench scenarios can show, by comparing each chip against a reference model:
- that each code maps data to the correct chip pair,
- that the pattern sequence is correct and repeats after 511 bits,
- that garbage driven on `din` between samples never reaches the output,
- that a mode change during a run is ignored.

// File: rtl/txline_pkg.sv
// Shared constants of the transmit line encoder: mode codes and pattern
// generator geometry. Assumes a 3-bit mode selector.
package txline_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] M_MAN_A  = 3'd0;
    localparam logic [MODE_W-1:0] M_MAN_B  = 3'd1;
    localparam logic [MODE_W-1:0] M_BP_MRK = 3'd2;
    localparam logic [MODE_W-1:0] M_BP_SPC = 3'd3;
    localparam logic [MODE_W-1:0] M_PRBS   = 3'd4;
    localparam int PN_LEN = 9;
    localparam int PN_TAP = 5;
endpackage

// File: rtl/txline_prbs.sv
// Pseudo-random pattern source: a Fibonacci shift register with feedback
// from stage LEN and stage TAP. Assumes that clear holds it at all ones
// and that step advances it by one bit.
module txline_prbs #(
    parameter int LEN = txline_pkg::PN_LEN,
    parameter int TAP = txline_pkg::PN_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic pn_bit
);
    logic [LEN-1:0] sr;

    assign pn_bit = sr[LEN-1];

    // Seed on clear, shift in the feedback bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr <= '1;
        end else if (step) begin
            sr <= {sr[LEN-2:0], sr[LEN-1] ^ sr[TAP-1]};
        end
    end

    // R8
    pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr != '0);
endmodule

// File: rtl/txline_sampler.sv
// Bit re-timer: captures one source bit (or pattern bit) at each bit start,
// holds it for the period and requests the next bit with a one-cycle pulse.
// Assumes that start is already qualified by the enable.
module txline_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic use_pn,
    input  logic pn_bit,
    input  logic din,
    output logic fresh,
    output logic cur_bit,
    output logic active,
    output logic req
);
    assign fresh = use_pn ? pn_bit : din;

    // Hold the sampled bit, mark a running bit and pulse the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cur_bit <= 1'b0;
            active  <= 1'b0;
            req     <= 1'b0;
        end else begin
            req <= 1'b0;
            if (start) begin
                cur_bit <= fresh;
                active  <= 1'b1;
                req     <= !use_pn;
            end
        end
    end
endmodule

// File: rtl/txline_former.sv
// Chip former: produces the first-half chip at a bit start and the
// second-half chip at mid-bit for the latched mode. Its own output
// register doubles as the Bi-Phase level memory, which is low while disabled.
module txline_former (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       start,
    input  logic       mid,
    input  logic [2:0] mode,
    input  logic       fresh,
    input  logic       cur_bit,
    output logic       chip
);
    import txline_pkg::*;
    logic first_c, second_c;
    logic is_man, is_bp;

    assign is_man = (mode == M_MAN_A) || (mode == M_MAN_B);
    assign is_bp  = (mode == M_BP_MRK) || (mode == M_BP_SPC);

    // Pick the two half-bit chip values for the current mode.
    always_comb begin
        case (mode)
            M_MAN_A:  begin first_c = fresh;  second_c = ~cur_bit; end
            M_MAN_B:  begin first_c = ~fresh; second_c = cur_bit;  end
            M_BP_MRK: begin first_c = ~chip;  second_c = cur_bit ? ~chip : chip; end
            M_BP_SPC: begin first_c = ~chip;  second_c = cur_bit ? chip : ~chip; end
            default:  begin first_c = fresh;  second_c = cur_bit;  end
        endcase
    end

    // Register the chip on each half-bit strobe, rest low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            chip <= 1'b0;
        end else if (start) begin
            chip <= first_c;
        end else if (mid) begin
            chip <= second_c;
        end
    end

    // R3 R4
    man_mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && is_man) |=> chip != $past(chip));
    // R5 R6
    bp_edge_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_bp) |=> chip != $past(chip));
endmodule

// File: rtl/txline_encoder.sv
// Multi-mode transmit line encoder top. Latches the mode while disabled and
// derives the bit-start and mid-bit events from the two strobes. Assumes
// that bit_stb is only raised together with chip_stb.
module txline_encoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       chip_stb,
    input  logic       enc_en,
    input  logic [2:0] mode_sel,
    input  logic       din,
    output logic       din_req,
    output logic       chip_out
);
    import txline_pkg::*;
    logic [MODE_W-1:0] mode_q;
    logic start, mid, use_pn, pn_bit, fresh, cur_bit, active;

    // Capture the mode only while the encoder is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_MAN_A;
        end else if (!enc_en) begin
            mode_q <= mode_sel;
        end
    end

    assign start  = enc_en && bit_stb && chip_stb;
    assign mid    = enc_en && active && chip_stb && !bit_stb;
    assign use_pn = (mode_q == M_PRBS);

    txline_prbs #(.LEN(PN_LEN), .TAP(PN_TAP)) u_pn (
        .clk(clk), .rst_n(rst_n), .clear(!enc_en),
        .step(start && use_pn), .pn_bit(pn_bit));

    txline_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .enable(enc_en), .start(start),
        .use_pn(use_pn), .pn_bit(pn_bit), .din(din), .fresh(fresh),
        .cur_bit(cur_bit), .active(active), .req(din_req));

    txline_former u_frm (
        .clk(clk), .rst_n(rst_n), .enable(enc_en), .start(start), .mid(mid),
        .mode(mode_q), .fresh(fresh), .cur_bit(cur_bit), .chip(chip_out));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_en |=> (!chip_out && !din_req));
    // R10
    req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_req |-> $past(bit_stb && chip_stb && enc_en));
    // R2
    chip_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_out != $past(chip_out)) |-> ($past(chip_stb) || !$past(enc_en)));
    // R12
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_en && $past(enc_en)) |-> $stable(mode_q));
endmodule

// File: tb/sim_txline_encoder.sv
module sim_txline_encoder;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_stb = 1'b0, chip_stb = 1'b0, enc_en = 1'b0, din = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic din_req, chip_out;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit bits [0:599];
    bit chips [0:1199];
    bit expc [0:1199];
    bit pn [0:1023];
    int n_req;

    always #5 clk = ~clk;

    txline_encoder u0 (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .chip_stb(chip_stb),
        .enc_en(enc_en), .mode_sel(mode_sel), .din(din), .din_req(din_req), .chip_out(chip_out));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model of the chip stream built from the requirements.
    task automatic build_expect(input int md, input int nb);
        bit lvl = 1'b0;
        for (int k = 0; k < nb; k++) begin
            bit d = (md == 4) ? pn[k] : bits[k];
            bit f, s;
            case (md)
                0: begin f = d; s = ~d; end
                1: begin f = ~d; s = d; end
                2: begin f = ~lvl; s = d ? ~f : f; lvl = s; end
                3: begin f = ~lvl; s = d ? f : ~f; lvl = s; end
                default: begin f = d; s = d; end
            endcase
            expc[2*k] = f;
            expc[2*k+1] = s;
        end
    endtask

    // One enabled run: strobes, data handshake with mid-bit garbage, chip capture.
    task automatic run(input int md, input int nb, input int swap_at, input int swap_md);
        int cnt = 0, ci = 0, idx = 0;
        bit prev_chip, last = 1'b0;
        mode_sel = 3'(md);
        din = bits[0];
        @(negedge clk);
        enc_en = 1'b1; bit_stb = 1'b1; chip_stb = 1'b1;
        n_req = 0;
        prev_chip = 1'b1;
        while (ci < 2*nb) begin
            @(negedge clk);
            if (prev_chip) begin
                chips[ci] = chip_out; last = chip_out; ci++;
            end else begin
                chk(chip_out == last, "R2 chip stable between strobes", chip_out, last);
            end
            if (din_req) begin
                n_req++; idx++;
                din = ~bits[idx];
                if (idx == swap_at) mode_sel = 3'(swap_md);
            end
            cnt++;
            if (cnt % 8 == 6) din = bits[idx];
            chip_stb = (cnt % 4 == 0);
            bit_stb = (cnt % 8 == 0);
            prev_chip = chip_stb;
        end
        enc_en = 1'b0; bit_stb = 1'b0; chip_stb = 1'b0;
        for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            chk(chip_out == 1'b0 && din_req == 1'b0, "R11 idle quiet", chip_out, 0);
        end
    endtask

    task automatic compare(input int md, input int nb, input string rq);
        build_expect(md, nb);
        for (int c = 0; c < 2*nb; c++)
            chk(chips[c] == expc[c], rq, chips[c], expc[c]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int n = 0; n < 1024; n++) pn[n] = (n < 9) ? 1'b1 : (pn[n-9] ^ pn[n-5]);
        repeat (3) @(negedge clk);
        chk(chip_out == 1'b0 && din_req == 1'b0, "R11 reset state", chip_out, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(chip_out == 1'b0 && din_req == 1'b0, "R11 disabled after reset", chip_out, 0);

        for (int md = 0; md < 8; md++) begin
            for (int k = 0; k < 600; k++) bits[k] = 1'($urandom);
            run(md, 40, -1, 0);
            case (md)
                0: compare(0, 40, "R3 Manchester-A");
                1: compare(1, 40, "R4 Manchester-B");
                2: compare(2, 40, "R5 Bi-Phase Mark");
                3: compare(3, 40, "R6 Bi-Phase Space");
                4: compare(4, 40, "R8 pattern");
                default: compare(md, 40, "R9 transparent retimed (R1 code)");
            endcase
            chk(n_req == ((md == 4) ? 0 : 40), "R10 request count", n_req, (md == 4) ? 0 : 40);
            if (md == 2 || md == 3) chk(chips[0] == 1'b1, "R7 first chip high", chips[0], 1);
        end

        for (int k = 0; k < 600; k++) bits[k] = 1'b0;
        run(2, 12, -1, 0); compare(2, 12, "R5 Bi-Phase Mark all zeros");
        run(3, 12, -1, 0); compare(3, 12, "R6 Bi-Phase Space all zeros");
        for (int k = 0; k < 600; k++) bits[k] = 1'b1;
        run(2, 12, -1, 0); compare(2, 12, "R5 Bi-Phase Mark all ones");
        run(0, 12, -1, 0); compare(0, 12, "R3 Manchester-A all ones");

        for (int k = 0; k < 600; k++) bits[k] = 1'($urandom);
        run(0, 30, 5, 3);
        compare(0, 30, "R12 mode change while enabled ignored");

        run(4, 520, -1, 0);
        compare(4, 520, "R8 pattern long run");
        for (int k = 0; k < 9; k++)
            chk(chips[2*(k+511)] == chips[2*k], "R8 period 511", chips[2*(k+511)], chips[2*k]);
        chk(n_req == 0, "R10 no request in pattern mode", n_req, 0);

        finish_run();
    end
endmodule